// File: doc/BRIEF.md
# MAC Event Interrupt Controller

This block collects single-cycle event pulses from the transmit path, the receive path and the control-frame logic of an Ethernet MAC. It holds them in a pending-event register and combines them with a separate enable register to drive one level-sensitive interrupt request line. Software reaches both registers over a simple register bus with byte addresses on 32-bit words. It reads the pending events and acknowledges them by writing ones. It sets up the enables by reading the enable word, changing it and writing it back.

A pending bit is recorded whether or not its event is enabled. To find the cause of an interrupt, the handler therefore combines the pending word with the enable word using AND. An event that arrives in the same cycle as an acknowledge of its own bit is kept, so it is never lost. The request line comes from a register and follows the pending and enable state with one cycle of delay.

Top module: `mac_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the pending register and the enable register both read 0, and `irq_o` is low.
- R2: A high `evt_pulse[i]` on a clock edge sets pending bit i, whatever the value of enable bit i. The bit assignment is: 0 transmit done, 1 transmit error, 2 receive frame, 3 receive error, 4 receive dropped for lack of a buffer, 5 transmit control frame, 6 receive control frame.
- R3: A write to the pending register at byte address 0x04 clears each bit written as 1. Bits written as 0 keep their value.
- R4: If an event pulse and an acknowledge reach the same pending bit in the same cycle, the bit stays set.
- R5: `irq_o` is high exactly when (pending AND enable) was nonzero at the previous clock edge. It therefore changes one cycle after the registers change.
- R6: The enable register at byte address 0x08 reads back the value last written to bits 6:0.
- R7: Bits 31:7 of both registers read as 0, and writes to those bits have no effect.
- R8: A read of any other address returns 0, and a write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational, and 0 when nothing is selected |
| evt_pulse | input | 7 | Single-cycle event pulses from the datapath |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
The bench sends single events and an all-events burst while every enable is off. Recording and signalling are separate functions, and this pattern shows that the pending bits fill in while the line stays quiet. It then narrows the enable word to one bit and uses acknowledges that are all zeros, partial, or collide with a fresh event on the same bit. These cases separate the clear-by-one behaviour from overwrite behaviour, and event-priority behaviour from clear-priority behaviour. It samples the request line both in the cycle right after an event and one cycle later, which shows the registered delay. Writes to unmapped addresses and all-ones writes show that neither register is touched outside its address and its seven bits.

// File: rtl/macirq_pkg.sv
package macirq_pkg;
    localparam int EVT_W  = 7;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] PEND_OFS = 8'h04;
    localparam logic [ADDR_W-1:0] ENAB_OFS = 8'h08;

    typedef enum int {
        EV_TX_DONE  = 0,
        EV_TX_ERR   = 1,
        EV_RX_FRAME = 2,
        EV_RX_ERR   = 3,
        EV_RX_BUSY  = 4,
        EV_TX_CTRL  = 5,
        EV_RX_CTRL  = 6
    } evt_idx_e;

    typedef struct packed {
        logic hit_pend;
        logic hit_enab;
        logic wr;
    } bus_dec_t;

    function automatic bus_dec_t decode(input logic sel, input logic we,
                                        input logic [ADDR_W-1:0] addr);
        bus_dec_t d;
        d.hit_pend = sel && (addr == PEND_OFS);
        d.hit_enab = sel && (addr == ENAB_OFS);
        d.wr       = sel && we;
        return d;
    endfunction
endpackage

// File: rtl/macirq_pend.sv
module macirq_pend #(
    parameter int EVT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic             ack_en,
    input  logic [EVT_W-1:0] ack_bits,
    output logic [EVT_W-1:0] pend_q
);
    logic [EVT_W-1:0] ack_eff;

    always_comb ack_eff = ack_en ? ack_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~ack_eff) | evt;
    end

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_en && ((ack_bits & ~evt) != '0)) |=> ((pend_q & $past(ack_bits & ~evt)) == '0));

    // R4
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_en && ((ack_bits & evt) != '0)) |=> ((pend_q & $past(ack_bits & evt)) == $past(ack_bits & evt)));
endmodule

// File: rtl/macirq_enab.sv
module macirq_enab #(
    parameter int EVT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [EVT_W-1:0] wr_bits,
    output logic [EVT_W-1:0] enab_q
);
    always_ff @(posedge clk) begin
        if (rst)        enab_q <= '0;
        else if (wr_en) enab_q <= wr_bits;
    end

    // R1
    enab_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (enab_q == '0));

    // R8
    enab_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(enab_q));
endmodule

// File: rtl/macirq_line.sv
module macirq_line #(
    parameter int EVT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] pend,
    input  logic [EVT_W-1:0] enab,
    output logic             irq_o
);
    logic [EVT_W-1:0] cause;

    always_comb cause = pend & enab;

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |cause;
    end

    // R5
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (cause != '0) |=> irq_o);

    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cause == '0) |=> !irq_o);
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl
    import macirq_pkg::*;
#(
    parameter int EW = macirq_pkg::EVT_W,
    parameter int DW = macirq_pkg::DATA_W,
    parameter int AW = macirq_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [EW-1:0] evt_pulse,
    output logic          irq_o
);
    localparam int PAD_W = DW - EW;

    bus_dec_t      dec;
    logic [EW-1:0] pend_q;
    logic [EW-1:0] enab_q;

    always_comb dec = decode(bus_sel, bus_we, bus_addr);

    macirq_pend #(.EVT_W(EW)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .ack_en   (dec.wr && dec.hit_pend),
        .ack_bits (bus_wdata[EW-1:0]),
        .pend_q   (pend_q)
    );

    macirq_enab #(.EVT_W(EW)) u_enab (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dec.wr && dec.hit_enab),
        .wr_bits (bus_wdata[EW-1:0]),
        .enab_q  (enab_q)
    );

    macirq_line #(.EVT_W(EW)) u_line (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend_q),
        .enab  (enab_q),
        .irq_o (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_we) begin
            if (dec.hit_pend)      bus_rdata = {{PAD_W{1'b0}}, pend_q};
            else if (dec.hit_enab) bus_rdata = {{PAD_W{1'b0}}, enab_q};
        end
    end

    // R1
    pend_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (pend_q == '0 && !irq_o));

    // R8
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.wr && !dec.hit_enab) |=> $stable(enab_q));

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we) |-> (bus_rdata[DW-1:EW] == '0 || bus_wdata == '1));
endmodule

// File: tb/mac_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mac_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  evt_pulse = '0;
    logic        irq_o;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    item_t it_w;
    item_t it_r;
    logic [31:0] act;
    logic chk_en = 1'b0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    localparam logic [7:0] A_PEND = 8'h04;
    localparam logic [7:0] A_ENAB = 8'h08;

    always #2.5 clk = ~clk;

    mac_irq_ctrl u_mac_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_pulse (evt_pulse),
        .irq_o     (irq_o)
    );

    // monitor: pops one expected item per sampling negedge
    always @(negedge clk) begin
        if (chk_en) begin
            it_r = q.pop_front();
            act  = (it_r.kind == 1) ? {31'b0, irq_o} : bus_rdata;
            n_vec++;
            if (act !== it_r.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it_r.tag, act, it_r.exp);
            end
        end
    end

    task automatic push(input int k, input logic [31:0] e, input string t);
        it_w.kind = k;
        it_w.exp  = e;
        it_w.tag  = t;
        q.push_back(it_w);
        chk_en = 1'b1;
        @(negedge clk);
        #1 chk_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        push(0, e, t);
        bus_sel = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string t);
        @(posedge clk); #1;
        push(1, {31'b0, e}, t);
    endtask

    task automatic irq_now(input logic e, input string t);
        push(1, {31'b0, e}, t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [6:0] ev);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; evt_pulse = ev;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; evt_pulse = '0;
    endtask

    task automatic pulse(input logic [6:0] v);
        @(posedge clk); #1 evt_pulse = v;
        @(posedge clk); #1 evt_pulse = '0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        rd_chk(A_PEND, 32'h0, "R1 pending after reset");
        rd_chk(A_ENAB, 32'h0, "R1 enable after reset");
        irq_chk(1'b0, "R1 irq after reset");

        pulse(7'h01);
        rd_chk(A_PEND, 32'h01, "R2 tx done latched while masked");
        irq_chk(1'b0, "R5 masked event keeps irq low");
        pulse(7'h7F);
        rd_chk(A_PEND, 32'h7F, "R2 all events latched");

        wr(A_ENAB, 32'hFFFF_FFFF, 7'h0);
        rd_chk(A_ENAB, 32'h7F, "R7 R6 enable upper bits dropped");
        irq_chk(1'b1, "R5 enabled pending raises irq");

        wr(A_PEND, 32'h0, 7'h0);
        rd_chk(A_PEND, 32'h7F, "R3 zero write keeps pending");
        wr(A_PEND, 32'h05, 7'h0);
        rd_chk(A_PEND, 32'h7A, "R3 partial acknowledge");

        wr(A_ENAB, 32'h04, 7'h0);
        rd_chk(A_ENAB, 32'h04, "R6 enable readback");
        irq_chk(1'b0, "R5 no enabled cause");

        pulse(7'h04);
        irq_now(1'b0, "R5 irq one cycle late");
        irq_chk(1'b1, "R5 irq after delay");

        wr(A_PEND, 32'h04, 7'h04);
        rd_chk(A_PEND, 32'h7E, "R4 event beats acknowledge");
        irq_chk(1'b1, "R4 irq stays high");
        wr(A_PEND, 32'h04, 7'h0);
        rd_chk(A_PEND, 32'h7A, "R3 acknowledge rx frame");
        irq_chk(1'b0, "R5 irq drops after acknowledge");

        wr(8'h0C, 32'hFFFF_FFFF, 7'h0);
        wr(8'h00, 32'hFFFF_FFFF, 7'h0);
        rd_chk(8'h0C, 32'h0, "R8 unmapped read 0x0C");
        rd_chk(8'h00, 32'h0, "R8 unmapped read 0x00");
        rd_chk(A_PEND, 32'h7A, "R8 pending untouched");
        rd_chk(A_ENAB, 32'h04, "R8 enable untouched");

        wr(A_PEND, 32'hFFFF_FF80, 7'h0);
        rd_chk(A_PEND, 32'h7A, "R7 upper acknowledge bits ignored");

        pulse(7'h04);
        irq_chk(1'b1, "R5 rx frame enabled");
        wr(A_ENAB, 32'h0, 7'h0);
        irq_chk(1'b0, "R5 enable cleared drops irq");

        wr(A_ENAB, 32'h7F, 7'h0);
        irq_chk(1'b1, "R5 before reset");
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        rd_chk(A_PEND, 32'h0, "R1 pending after mid-run reset");
        rd_chk(A_ENAB, 32'h0, "R1 enable after mid-run reset");
        irq_chk(1'b0, "R1 irq after mid-run reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule